// File: doc/BRIEF.md
# Two-Part Inter-Frame Deferral Timer

This block decides when a queued transmission may start on a shared, carrier-sensed medium. It watches the medium's carrier sense and the local transmitter's activity flag, and once both are quiet it times an inter-frame gap counted in bit times. The gap has two parts. In the first part any carrier activity zeroes the timer and the block keeps yielding to the arriving receive frame. In the second part carrier is ignored: a pending transmission starts at the end of the gap even if that causes a collision. This rule keeps access to the medium fair.

A bit-time enable sets the time base. The defaults of 60 and 96 bit times give 6.0 us and 9.6 us at 10 Mb/s. Both part lengths are parameters. Setting the first part to zero gives plain single-part deferral. The grant is a one-cycle pulse. After it the block waits for the medium to go quiet again. Backoff, jam and the transmitter itself sit outside this block.

Top module: `ifg_defer`

## Requirements
- R1: While reset is held and in the first cycle after it, `txGrant` is 0 and `rxYield` is 1. The block begins in the busy-wait state with its gap count at zero.
- R2: The gap starts at the first clock edge where `carrierSense` and `txActive` are both sampled low. `txGrant` is high in the cycle that begins one edge after the edge at which the GAP_BITS-th bit tick of the gap is counted. With a tick every cycle, that is cycle GAP_BITS+1, where cycle 0 follows the start edge.
- R3: Suppose `carrierSense` is sampled high at an edge when fewer than PART1_BITS ticks have been counted in the gap. The count then returns to zero. The gap starts again at the next edge where the medium is quiet.
- R4: Once PART1_BITS ticks have been counted, `carrierSense` no longer affects the gap. A pending request is granted at the end of the gap even while carrier is high.
- R5: `txGrant` is never high for two cycles in a row. After a grant the block returns to busy-wait and times a new gap.
- R6: If `txPending` is low when the gap ends, the block stays with the gap satisfied. `txGrant` then goes high in the same cycle that `txPending` rises, since the path from request to grant has no register.
- R7: If `carrierSense` is sampled high while the gap is satisfied and nothing is pending, the block goes back to busy-wait, and `rxYield` rises.
- R8: `rxYield` is 1 during busy-wait and during the first part of the gap. It is 0 during the second part and while the gap is satisfied. With a tick every cycle, it is 1 in cycle PART1_BITS of the gap and 0 in cycle PART1_BITS+1.
- R9: Only edges at which `bitTick` is high advance the gap count. With a tick in every third cycle, the grant comes in cycle 3*GAP_BITS+1.
- R10: With PART1_BITS = 0, carrier never restarts a gap once it has started, and the grant comes in cycle GAP_BITS+1.
- R11: `txActive` high has the same effect as carrier in busy-wait and in the first part: it holds or restarts the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle enable per bit time |
| carrierSense | input | 1 | Medium carrier detected |
| txActive | input | 1 | Local transmitter is sending |
| txPending | input | 1 | A frame is waiting to be sent |
| txGrant | output | 1 | One-cycle permission to start transmitting |
| rxYield | output | 1 | High while the block defers to the medium |

## Verification
A wrong gap count or a missed phase change shows up as a grant that comes early, late or twice. The bench measures this to the exact cycle: it places one carrier pulse at each point of the gap and compares the grant cycle against the two-part formula. A wrong first-part boundary moves the grant by a full gap length, and a count that ignores the tick enable moves it by a factor of the tick period. Either error shows within one gap. A wrong phase state is also visible on `rxYield` in the cycle where the first part ends.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

  typedef enum logic [1:0] {
    ST_BUSY  = 2'd0,
    ST_PART1 = 2'd1,
    ST_PART2 = 2'd2,
    ST_READY = 2'd3
  } ifgState_t;

  typedef struct packed {
    logic clear;
    logic advance;
  } ifgStrobes_t;

endpackage

// File: rtl/ifg_datapath.sv
module ifg_datapath
  import ifg_pkg::*;
#(
  parameter int PART1_BITS = 60,
  parameter int GAP_BITS   = 96
) (
  input  logic        clk,
  input  logic        rstN,
  input  ifgStrobes_t strb,
  output logic        hitPart1,
  output logic        hitGap
);
  localparam int CNT_W = $clog2(GAP_BITS + 1);
  localparam logic [CNT_W-1:0] P1_CNT  = CNT_W'(PART1_BITS);
  localparam logic [CNT_W-1:0] GAP_CNT = CNT_W'(GAP_BITS);

  logic [CNT_W-1:0] gapCount;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      gapCount <= '0;
    end else if (strb.advance && (gapCount < GAP_CNT)) begin
      gapCount <= gapCount + 1'b1;
    end
  end

  assign hitPart1 = (gapCount >= P1_CNT);
  assign hitGap   = (gapCount >= GAP_CNT);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    gapCount <= GAP_CNT);

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (gapCount == '0));

  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clear) |=> $stable(gapCount));

endmodule

// File: rtl/ifg_control.sv
module ifg_control
  import ifg_pkg::*;
#(
  parameter int PART1_BITS = 60
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        carrierSense,
  input  logic        txActive,
  input  logic        txPending,
  input  logic        hitPart1,
  input  logic        hitGap,
  output ifgStrobes_t strb,
  output logic        txGrant,
  output logic        rxYield
);
  localparam bit SINGLE_PART = (PART1_BITS == 0);

  ifgState_t state, nextState;
  logic mediumBusy;

  assign mediumBusy = carrierSense | txActive;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_BUSY: begin
        if (!mediumBusy) nextState = SINGLE_PART ? ST_PART2 : ST_PART1;
      end
      ST_PART1: begin
        if (hitPart1)        nextState = ST_PART2;
        else if (mediumBusy) nextState = ST_BUSY;
      end
      ST_PART2: begin
        if (hitGap) nextState = ST_READY;
      end
      ST_READY: begin
        if (txPending)         nextState = ST_BUSY;
        else if (carrierSense) nextState = ST_BUSY;
      end
      default: nextState = ST_BUSY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_BUSY;
    else       state <= nextState;
  end

  always_comb begin
    strb.clear   = (state == ST_BUSY) || (nextState == ST_BUSY);
    strb.advance = bitTick && ((state == ST_PART1) || (state == ST_PART2));
  end

  assign txGrant = (state == ST_READY) && txPending;
  assign rxYield = (state == ST_BUSY) || (state == ST_PART1);

  p_grant_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |=> !txGrant);

  p_grant_after_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |-> hitGap);

  p_part2_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PART2 && !hitGap) |=> (state == ST_PART2 || state == ST_READY));

  p_early_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PART1 && !hitPart1 && carrierSense) |=> (state == ST_BUSY && rxYield));

  p_idle_carrier_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && !txPending && carrierSense) |=> rxYield);

endmodule

// File: rtl/ifg_defer.sv
module ifg_defer
  import ifg_pkg::*;
#(
  parameter int PART1_BITS = 60,
  parameter int GAP_BITS   = 96
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic carrierSense,
  input  logic txActive,
  input  logic txPending,
  output logic txGrant,
  output logic rxYield
);
  ifgStrobes_t strb;
  logic hitPart1, hitGap;

  ifg_control #(.PART1_BITS(PART1_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .carrierSense(carrierSense), .txActive(txActive), .txPending(txPending),
    .hitPart1(hitPart1), .hitGap(hitGap),
    .strb(strb), .txGrant(txGrant), .rxYield(rxYield)
  );

  ifg_datapath #(.PART1_BITS(PART1_BITS), .GAP_BITS(GAP_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hitPart1(hitPart1), .hitGap(hitGap)
  );

  initial begin
    assert (PART1_BITS >= 0 && PART1_BITS < GAP_BITS)
      else $error("part-one length must be below the full gap");
  end

endmodule

// File: tb/ifg_defer_tb.sv
module ifg_defer_tb;
  localparam int P1A = 6, GAPA = 10;
  localparam int P1B = 0, GAPB = 5;

  logic clk = 0, rstN = 0;
  logic bitTick = 1, carrierSense = 1, txActive = 0, txPending = 0;
  logic grantA, yieldA, grantB, yieldB;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ifg_defer #(.PART1_BITS(P1A), .GAP_BITS(GAPA)) u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .carrierSense(carrierSense),
    .txActive(txActive), .txPending(txPending), .txGrant(grantA), .rxYield(yieldA));

  ifg_defer #(.PART1_BITS(P1B), .GAP_BITS(GAPB)) u_dut_b (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .carrierSense(carrierSense),
    .txActive(txActive), .txPending(txPending), .txGrant(grantB), .rxYield(yieldB));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold the medium busy, release it, then run one gap.
  // pulseAt: cycle of a one-cycle pulse (-1 none); useTx picks txActive over carrier.
  task automatic runGap(input bit useB, input int div, input int pulseAt, input bit useTx,
                        output int firstGrant, output int grants, output int yP1, output int yP1n);
    int p1 = useB ? P1B : P1A;
    firstGrant = -1; grants = 0; yP1 = -1; yP1n = -1;
    txPending = 1; bitTick = 1; carrierSense = 1; txActive = 0;
    repeat (3) @(posedge clk);
    #1 carrierSense = 0;
    for (int j = 0; j < 45; j++) begin
      @(posedge clk);
      #1;
      carrierSense = (!useTx && j == pulseAt);
      txActive     = (useTx && j == pulseAt);
      bitTick      = (div == 1) ? 1'b1 : ((j % div) == div - 1);
      if (firstGrant >= 0) txPending = 0;
      @(negedge clk);
      if ((useB ? grantB : grantA) == 1'b1) begin
        grants++;
        if (firstGrant < 0) firstGrant = j;
      end
      if (j == p1)     yP1  = useB ? yieldB : yieldA;
      if (j == p1 + 1) yP1n = useB ? yieldB : yieldA;
    end
    carrierSense = 1; txActive = 0; bitTick = 1;
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int fg, ng, y1, y2, exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 grant in reset", grantA, 0);
    check("R1 yield in reset", yieldA, 1);
    #1 rstN = 1;
    @(negedge clk);
    check("R1 grant after reset", grantA, 0);
    check("R1 yield after reset", yieldA, 1);

    // R2 plain gap, R8 yield boundary, R5 single pulse
    runGap(0, 1, -1, 0, fg, ng, y1, y2);
    check("R2 grant cycle", fg, GAPA + 1);
    check("R5 grant count", ng, 1);
    check("R8 yield at part-one end", y1, 1);
    check("R8 yield in part two", y2, 0);

    // R3 / R4 sweep of carrier pulse position
    for (int i = 0; i <= GAPA + 1; i++) begin
      runGap(0, 1, i, 0, fg, ng, y1, y2);
      exp = (i < P1A) ? (i + 2 + GAPA + 1) : (GAPA + 1);
      check((i < P1A) ? "R3 restart grant cycle" : "R4 ignore carrier grant cycle", fg, exp);
      check("R5 single grant per gap", ng, 1);
    end

    // R11 transmitter activity restarts part one
    runGap(0, 1, 2, 1, fg, ng, y1, y2);
    check("R11 txActive restart", fg, 2 + 2 + GAPA + 1);
    runGap(0, 1, P1A + 1, 1, fg, ng, y1, y2);
    check("R11 txActive late ignored", fg, GAPA + 1);

    // R9 time base
    runGap(0, 3, -1, 0, fg, ng, y1, y2);
    check("R9 tick every third cycle", fg, 3 * GAPA + 1);

    // R10 single-part instance
    for (int i = -1; i <= GAPB + 1; i++) begin
      runGap(1, 1, i, 0, fg, ng, y1, y2);
      check("R10 single-part grant cycle", fg, GAPB + 1);
    end

    // R6 idle wait then immediate grant, R7 carrier while idle
    txPending = 0; carrierSense = 1;
    repeat (2) @(posedge clk);
    #1 carrierSense = 0;
    repeat (GAPA + 5) @(posedge clk);
    @(negedge clk);
    check("R6 no grant while idle", grantA, 0);
    check("R8 yield low when satisfied", yieldA, 0);
    txPending = 1;
    #1;
    check("R6 grant same cycle as request", grantA, 1);
    @(posedge clk);
    #1 txPending = 0;
    repeat (GAPA + 5) @(posedge clk);
    #1 carrierSense = 1;
    @(posedge clk);
    #1 carrierSense = 0;
    @(negedge clk);
    check("R7 yield after idle carrier", yieldA, 1);
    txPending = 1;
    #1;
    check("R7 no grant after idle carrier", grantA, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule